// File: doc/BRIEF.md
# Ethernet Transmit Frame Classifier

This block sits beside a transmit path and watches frames go by, one byte per cycle. Each byte beat comes with a valid flag, first-byte and last-byte marks, and two per-frame flags: one for a bad frame check sequence and one saying the CRC was left to the user (skip-CRC). The block works out the frame's length, destination class, Length/Type meaning and control opcode as the bytes pass. It keeps no history between frames other than the header fields of the frame in progress.

One cycle after the last byte of a frame, the block drives a vector of single-cycle increment strobes for a bank of statistics counters. The strobes cover size bins, oversize, three kinds of CRC error by size, good and errored destination classes split into data and control, pause and priority flow-control frames, out-of-range Length/Type values, a short advertised length and dropped runts. A further strobe marks every frame start. The maximum legal frame size, VLAN tag look-through and length checking are configuration inputs, held steady while frames flow.

Top module: `tx_frame_classifier`

## Requirements
- R1: While reset is asserted, and after release until the first frame byte, `o_stat` is all zero.
- R2: Bit 0 of `o_stat` is high for exactly the one cycle after each beat with `i_vld` and `i_sof` both high.
- R3: Frame length counts the valid beats from the start beat through the end beat, including the FCS bytes. A frame no longer than `i_max_size` raises exactly one size bin: bit 4 for 64 bytes, 5 for 65–127, 6 for 128–255, 7 for 256–511, 8 for 512–1023, 9 for 1024–1518 and 10 for 1519 up to `i_max_size`. Frames under 64 bytes raise no bin.
- R4: A frame longer than `i_max_size` raises bit 11 and no size bin.
- R5: With `i_fcs_err` set on the end beat, bit 1 is raised below 64 bytes, bit 2 above `i_max_size`, and bit 3 at any length in between.
- R6: The destination address (first six bytes) is broadcast when all ones, multicast when bit 0 of byte 0 is set, and unicast otherwise. A frame is control when its Length/Type equals 0x8808 and data otherwise. Good frames raise one of bits 12/13/14 (data: unicast/multicast/broadcast) or 15/16/17 (control). Errored frames raise one of bits 18–20 (data) or 21–23 (control) in the same order.
- R7: In a control frame, an opcode (the two bytes after the Length/Type) of 0x0001 raises bit 24 when good or bit 25 when errored. An opcode of 0x0101 raises bit 26 when good or bit 27 when errored.
- R8: A Length/Type value from 1501 through 1535 raises bit 28; values of 1500 or less, and of 1536 or more, do not.
- R9: The Length/Type field sits at bytes 12–13. With `i_vlan_en` high, up to two tags whose first two bytes are 0x8100 or 0x88A8 are stepped over, four bytes each, and the field after them is used. With `i_vlan_en` low, the tag identifier itself is the Length/Type.
- R10: With `i_len_chk_en` high, a Length/Type of 1500 or less that exceeds the payload raises bit 29. The payload is the frame length minus the header through the Length/Type and the 4 FCS bytes, and is never below zero. With `i_len_chk_en` low, bit 29 stays low.
- R11: With `i_skip_crc` set on the end beat and a length below 21 bytes, bit 30 is the only end-of-frame strobe raised. At 21 bytes and above, skip-CRC has no effect.
- R12: Bits 1 to 30 are raised only in the cycle after an end beat, and bursts with idle beats inside a frame or with no gap between frames classify the same as unbroken ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_vld | input | 1 | Byte beat valid |
| i_sof | input | 1 | Beat holds the first frame byte |
| i_eof | input | 1 | Beat holds the last frame byte |
| i_data | input | 8 | Frame byte |
| i_fcs_err | input | 1 | Frame carries a bad FCS (sampled on the end beat) |
| i_skip_crc | input | 1 | CRC is supplied by the user (sampled on the end beat) |
| i_max_size | input | 16 | Largest legal frame length in bytes |
| i_vlan_en | input | 1 | Look through VLAN tags for the Length/Type |
| i_len_chk_en | input | 1 | Enable the advertised-length check |
| o_stat | output | 31 | Increment strobe vector, one cycle after the beat |

## Verification
The scoreboard feeds frames at every bin edge (63/64/65 through 1518/1519, and the configured maximum and one above). This separates off-by-one faults in each comparator from faults in how the maximum is applied. Unicast, multicast and broadcast addresses are each sent good and errored, and as data and control, so that a wrong class index or a swapped good/error base shows up as a different strobe. Length/Type values at 1500, 1501, 1535 and 1536 bracket the dead band. The same tagged frames are sent with tag look-through on and off to tell a skipped tag from a misplaced field. Runts with skip-CRC at 20 and 21 bytes, frames with idle beats inside, and back-to-back frames check that suppression and accumulation reset at the right byte.

// File: rtl/tx_cls_pkg.sv
package tx_cls_pkg;
  localparam int STAT_W     = 31;
  localparam int ST_START   = 0;
  localparam int ST_FRAG    = 1;
  localparam int ST_JABBER  = 2;
  localparam int ST_CRC_MID = 3;
  localparam int ST_BIN0    = 4;
  localparam int N_BINS     = 7;
  localparam int ST_OVER    = 11;
  localparam int ST_OK_DAT  = 12;
  localparam int ST_OK_CTL  = 15;
  localparam int ST_ER_DAT  = 18;
  localparam int ST_ER_CTL  = 21;
  localparam int ST_PAU_OK  = 24;
  localparam int ST_PAU_ER  = 25;
  localparam int ST_PFC_OK  = 26;
  localparam int ST_PFC_ER  = 27;
  localparam int ST_BAD_LT  = 28;
  localparam int ST_LEN_ER  = 29;
  localparam int ST_DROP    = 30;

  localparam logic [15:0] ET_MAC_CTL = 16'h8808;
  localparam logic [15:0] OP_PAUSE   = 16'h0001;
  localparam logic [15:0] OP_PFC     = 16'h0101;
  localparam logic [15:0] TPID_C     = 16'h8100;
  localparam logic [15:0] TPID_S     = 16'h88A8;
  localparam int unsigned LT_LEN_MAX  = 1500;
  localparam int unsigned LT_TYPE_MIN = 1536;
  localparam int unsigned ADDR_BYTES  = 6;
  localparam int unsigned LT_OFFSET   = 12;
  localparam int unsigned TAG_BYTES   = 4;
  localparam int unsigned FCS_BYTES   = 4;
endpackage

// File: rtl/tx_cls_parse.sv
module tx_cls_parse
  import tx_cls_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int TAG_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_vld,
  input  logic             i_sof,
  input  logic [7:0]       i_data,
  input  logic             i_vlan_en,
  output logic [LEN_W-1:0] o_len,
  output logic             o_bc,
  output logic             o_mc,
  output logic [15:0]      o_lt,
  output logic             o_lt_ok,
  output logic [LEN_W-1:0] o_lt_pos,
  output logic [15:0]      o_op,
  output logic             o_op_ok
);
  localparam int TAG_W = $clog2(TAG_MAX + 1);

  logic [LEN_W-1:0] cnt_q, cnt_b, cnt_n;
  logic             bc_q, bc_b, bc_n;
  logic             mc_q, mc_b, mc_n;
  logic [15:0]      lt_q, lt_b, lt_n;
  logic             ltok_q, ltok_b, ltok_n;
  logic [TAG_W-1:0] tags_q, tags_b, tags_n;
  logic [LEN_W-1:0] pos_q, pos_b, pos_n;
  logic [15:0]      op_q, op_b, op_n;
  logic             opok_q, opok_b, opok_n;
  logic [15:0]      lt_word;

  // Start beat restarts every accumulator before this byte is applied.
  always_comb begin
    cnt_b  = i_sof ? '0 : cnt_q;
    bc_b   = i_sof ? 1'b1 : bc_q;
    mc_b   = i_sof ? 1'b0 : mc_q;
    lt_b   = i_sof ? '0 : lt_q;
    ltok_b = i_sof ? 1'b0 : ltok_q;
    tags_b = i_sof ? '0 : tags_q;
    pos_b  = i_sof ? LEN_W'(LT_OFFSET) : pos_q;
    op_b   = i_sof ? '0 : op_q;
    opok_b = i_sof ? 1'b0 : opok_q;
  end

  assign lt_word = {lt_b[15:8], i_data};

  always_comb begin
    bc_n   = bc_b;
    mc_n   = mc_b;
    lt_n   = lt_b;
    ltok_n = ltok_b;
    tags_n = tags_b;
    pos_n  = pos_b;
    op_n   = op_b;
    opok_n = opok_b;
    if (cnt_b < LEN_W'(ADDR_BYTES)) bc_n = bc_b & (i_data == 8'hFF);
    if (cnt_b == '0) mc_n = i_data[0];
    if (!ltok_b) begin
      if (cnt_b == pos_b) lt_n[15:8] = i_data;
      if (cnt_b == pos_b + LEN_W'(1)) begin
        lt_n[7:0] = i_data;
        if (i_vlan_en && (tags_b < TAG_W'(TAG_MAX)) &&
            (lt_word == TPID_C || lt_word == TPID_S)) begin
          pos_n  = pos_b + LEN_W'(TAG_BYTES);
          tags_n = tags_b + TAG_W'(1);
        end else begin
          ltok_n = 1'b1;
        end
      end
    end else if (!opok_b) begin
      if (cnt_b == pos_b + LEN_W'(2)) op_n[15:8] = i_data;
      if (cnt_b == pos_b + LEN_W'(3)) begin
        op_n[7:0] = i_data;
        opok_n    = 1'b1;
      end
    end
    cnt_n = (&cnt_b) ? cnt_b : cnt_b + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bc_q   <= 1'b0;
      mc_q   <= 1'b0;
      lt_q   <= '0;
      ltok_q <= 1'b0;
      tags_q <= '0;
      pos_q  <= '0;
      op_q   <= '0;
      opok_q <= 1'b0;
    end else if (i_vld) begin
      cnt_q  <= cnt_n;
      bc_q   <= bc_n;
      mc_q   <= mc_n;
      lt_q   <= lt_n;
      ltok_q <= ltok_n;
      tags_q <= tags_n;
      pos_q  <= pos_n;
      op_q   <= op_n;
      opok_q <= opok_n;
    end
  end

  assign o_len    = cnt_n;
  assign o_bc     = bc_n && (cnt_n >= LEN_W'(ADDR_BYTES));
  assign o_mc     = mc_n;
  assign o_lt     = lt_n;
  assign o_lt_ok  = ltok_n;
  assign o_lt_pos = pos_n;
  assign o_op     = op_n;
  assign o_op_ok  = opok_n;
endmodule

// File: rtl/tx_cls_size.sv
module tx_cls_size
  import tx_cls_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_FRM = 64,
  parameter int STD_MAX = 1518
) (
  input  logic [LEN_W-1:0]  i_len,
  input  logic [LEN_W-1:0]  i_max,
  output logic [N_BINS-1:0] o_bin,
  output logic              o_under,
  output logic              o_over
);
  function automatic int unsigned bin_lo(int k);
    case (k)
      0:       return MIN_FRM;
      1:       return MIN_FRM + 1;
      default: return (MIN_FRM << (k - 1));
    endcase
  endfunction

  function automatic int unsigned bin_hi(int k);
    if (k == 0) return MIN_FRM;
    if (k == N_BINS - 2) return STD_MAX;
    return (MIN_FRM << k) - 1;
  endfunction

  assign o_over  = i_len > i_max;
  assign o_under = 32'(i_len) < MIN_FRM;

  for (genvar k = 0; k < N_BINS - 1; k++) begin : g_bin
    assign o_bin[k] = !o_over && (32'(i_len) >= bin_lo(k)) && (32'(i_len) <= bin_hi(k));
  end
  assign o_bin[N_BINS-1] = !o_over && (32'(i_len) > STD_MAX);
endmodule

// File: rtl/tx_cls_decide.sv
module tx_cls_decide
  import tx_cls_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int DROP_MIN = 21
) (
  input  logic [LEN_W-1:0]  i_len,
  input  logic              i_err,
  input  logic              i_skip,
  input  logic              i_chk_en,
  input  logic [N_BINS-1:0] i_bin,
  input  logic              i_under,
  input  logic              i_over,
  input  logic              i_bc,
  input  logic              i_mc,
  input  logic [15:0]       i_lt,
  input  logic              i_lt_ok,
  input  logic [LEN_W-1:0]  i_lt_pos,
  input  logic [15:0]       i_op,
  input  logic              i_op_ok,
  output logic [STAT_W-1:0] o_vec
);
  logic [2:0]   cls;
  logic         ctrl;
  logic [LEN_W:0] hdr_fcs;
  logic [LEN_W:0] payload;

  assign cls     = {i_bc, i_mc & ~i_bc, ~i_mc & ~i_bc};
  assign ctrl    = i_lt_ok && (i_lt == ET_MAC_CTL);
  assign hdr_fcs = {1'b0, i_lt_pos} + (LEN_W+1)'(2 + FCS_BYTES);
  assign payload = ({1'b0, i_len} > hdr_fcs) ? {1'b0, i_len} - hdr_fcs : '0;

  always_comb begin
    o_vec = '0;
    if (i_skip && (32'(i_len) < DROP_MIN)) begin
      o_vec[ST_DROP] = 1'b1;
    end else begin
      o_vec[ST_BIN0 +: N_BINS] = i_bin;
      o_vec[ST_OVER]    = i_over;
      o_vec[ST_FRAG]    = i_err && i_under;
      o_vec[ST_JABBER]  = i_err && i_over;
      o_vec[ST_CRC_MID] = i_err && !i_under && !i_over;
      for (int c = 0; c < 3; c++) begin
        o_vec[ST_OK_DAT + c] = !i_err && !ctrl && cls[c];
        o_vec[ST_OK_CTL + c] = !i_err &&  ctrl && cls[c];
        o_vec[ST_ER_DAT + c] =  i_err && !ctrl && cls[c];
        o_vec[ST_ER_CTL + c] =  i_err &&  ctrl && cls[c];
      end
      o_vec[ST_PAU_OK] = ctrl && i_op_ok && (i_op == OP_PAUSE) && !i_err;
      o_vec[ST_PAU_ER] = ctrl && i_op_ok && (i_op == OP_PAUSE) &&  i_err;
      o_vec[ST_PFC_OK] = ctrl && i_op_ok && (i_op == OP_PFC)   && !i_err;
      o_vec[ST_PFC_ER] = ctrl && i_op_ok && (i_op == OP_PFC)   &&  i_err;
      o_vec[ST_BAD_LT] = i_lt_ok && (32'(i_lt) > LT_LEN_MAX) && (32'(i_lt) < LT_TYPE_MIN);
      o_vec[ST_LEN_ER] = i_chk_en && i_lt_ok && (32'(i_lt) <= LT_LEN_MAX) &&
                         (32'(i_lt) > 32'(payload));
    end
  end
endmodule

// File: rtl/tx_frame_classifier.sv
module tx_frame_classifier
  import tx_cls_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int TAG_MAX  = 2,
  parameter int MIN_FRM  = 64,
  parameter int STD_MAX  = 1518,
  parameter int DROP_MIN = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_vld,
  input  logic              i_sof,
  input  logic              i_eof,
  input  logic [7:0]        i_data,
  input  logic              i_fcs_err,
  input  logic              i_skip_crc,
  input  logic [LEN_W-1:0]  i_max_size,
  input  logic              i_vlan_en,
  input  logic              i_len_chk_en,
  output logic [STAT_W-1:0] o_stat
);
  logic [LEN_W-1:0]  len, lt_pos;
  logic              bc, mc, lt_ok, op_ok, under, over;
  logic [15:0]       lt, op;
  logic [N_BINS-1:0] bin;
  logic [STAT_W-1:0] end_vec, stat_d, stat_q;

  tx_cls_parse #(.LEN_W(LEN_W), .TAG_MAX(TAG_MAX)) u_parse (
    .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_sof(i_sof), .i_data(i_data),
    .i_vlan_en(i_vlan_en), .o_len(len), .o_bc(bc), .o_mc(mc), .o_lt(lt),
    .o_lt_ok(lt_ok), .o_lt_pos(lt_pos), .o_op(op), .o_op_ok(op_ok)
  );

  tx_cls_size #(.LEN_W(LEN_W), .MIN_FRM(MIN_FRM), .STD_MAX(STD_MAX)) u_size (
    .i_len(len), .i_max(i_max_size), .o_bin(bin), .o_under(under), .o_over(over)
  );

  tx_cls_decide #(.LEN_W(LEN_W), .DROP_MIN(DROP_MIN)) u_decide (
    .i_len(len), .i_err(i_fcs_err), .i_skip(i_skip_crc), .i_chk_en(i_len_chk_en),
    .i_bin(bin), .i_under(under), .i_over(over), .i_bc(bc), .i_mc(mc),
    .i_lt(lt), .i_lt_ok(lt_ok), .i_lt_pos(lt_pos), .i_op(op), .i_op_ok(op_ok),
    .o_vec(end_vec)
  );

  always_comb begin
    stat_d = '0;
    if (i_vld && i_eof) stat_d = end_vec;
    if (i_vld && i_sof) stat_d[ST_START] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign o_stat = stat_q;
endmodule

// File: rtl/tx_frame_classifier_chk.sv
module tx_frame_classifier_chk
  import tx_cls_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              i_vld,
  input logic              i_sof,
  input logic              i_eof,
  input logic [STAT_W-1:0] o_stat
);
  logic [STAT_W-1:0] end_bits;
  assign end_bits = o_stat & ~(STAT_W'(1) << ST_START);

  p_start_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && i_sof) |=> o_stat[ST_START]);

  p_no_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(i_vld && i_sof) |=> !o_stat[ST_START]);

  p_end_after_eof_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(i_vld && i_eof) |=> (end_bits == '0));

  p_one_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(o_stat[ST_OVER:ST_BIN0]));

  p_crc_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(o_stat[ST_CRC_MID:ST_FRAG]));

  p_one_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(o_stat[ST_ER_CTL+2:ST_OK_DAT]));

  p_pause_is_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_stat[ST_PAU_OK] || o_stat[ST_PFC_OK]) |-> (|o_stat[ST_OK_CTL+2:ST_OK_CTL]));

  p_lt_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(o_stat[ST_BAD_LT] && o_stat[ST_LEN_ER]));

  p_drop_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    o_stat[ST_DROP] |-> ($countones(end_bits) == 1));
endmodule

bind tx_frame_classifier tx_frame_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_sof(i_sof), .i_eof(i_eof), .o_stat(o_stat)
);

// File: tb/tx_frame_classifier_bench.sv
module tx_frame_classifier_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        i_vld, i_sof, i_eof, i_fcs_err, i_skip_crc, i_vlan_en, i_len_chk_en;
  logic [7:0]  i_data;
  logic [15:0] i_max_size;
  logic [30:0] o_stat;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [30:0] exp_q[$];
  string       tag_q[$];

  always #5ns clk = ~clk;

  tx_frame_classifier u_tx_frame_classifier (
    .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_sof(i_sof), .i_eof(i_eof),
    .i_data(i_data), .i_fcs_err(i_fcs_err), .i_skip_crc(i_skip_crc),
    .i_max_size(i_max_size), .i_vlan_en(i_vlan_en), .i_len_chk_en(i_len_chk_en),
    .o_stat(o_stat)
  );

  function automatic logic [30:0] model(int len, int kind, int ntags, logic [15:0] lt,
                                         logic [15:0] op, bit err, bit skip);
    logic [30:0] v = '0;
    logic [15:0] elt;
    int hdr, pay, base;
    bit over, ctrl;
    if (skip && len < 21) begin v[30] = 1'b1; return v; end
    over = len > int'(i_max_size);
    if (!over) begin
      if (len == 64) v[4] = 1'b1;
      else if (len >= 65 && len <= 127) v[5] = 1'b1;
      else if (len >= 128 && len <= 255) v[6] = 1'b1;
      else if (len >= 256 && len <= 511) v[7] = 1'b1;
      else if (len >= 512 && len <= 1023) v[8] = 1'b1;
      else if (len >= 1024 && len <= 1518) v[9] = 1'b1;
      else if (len >= 1519) v[10] = 1'b1;
    end
    v[11] = over;
    if (err) begin
      if (len < 64) v[1] = 1'b1; else if (over) v[2] = 1'b1; else v[3] = 1'b1;
    end
    if (i_vlan_en || ntags == 0) begin elt = lt; hdr = 14 + 4 * ntags; end
    else begin elt = (ntags == 2) ? 16'h88A8 : 16'h8100; hdr = 14; end
    ctrl = (elt == 16'h8808);
    base = err ? 18 : 12;
    v[base + (ctrl ? 3 : 0) + kind] = 1'b1;
    if (ctrl && op == 16'h0001) v[err ? 25 : 24] = 1'b1;
    if (ctrl && op == 16'h0101) v[err ? 27 : 26] = 1'b1;
    if (elt >= 1501 && elt <= 1535) v[28] = 1'b1;
    if (i_len_chk_en && elt <= 1500) begin
      pay = len - hdr - 4;
      if (pay < 0) pay = 0;
      if (int'(elt) > pay) v[29] = 1'b1;
    end
    return v;
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      i_vld = 1'b0; i_sof = 1'b0; i_eof = 1'b0;
    end
  endtask

  // kind: 0 unicast, 1 multicast, 2 broadcast. gap_at: idle beat before that byte.
  task automatic send(string tag, int len, int kind, int ntags, logic [15:0] lt,
                      logic [15:0] op, bit err, bit skip, int gap_at);
    logic [7:0] fb[0:2047];
    int p;
    for (int i = 0; i < 2048; i++) fb[i] = 8'h00;
    for (int i = 0; i < 6; i++)
      fb[i] = (kind == 2) ? 8'hFF : (kind == 1) ? ((i == 0) ? 8'h01 : 8'h5E) :
              ((i == 0) ? 8'h02 : 8'h33);
    for (int i = 6; i < 12; i++) fb[i] = 8'hAA;
    p = 12;
    for (int t = 0; t < ntags; t++) begin
      {fb[p], fb[p+1]} = (t == 0 && ntags == 2) ? 16'h88A8 : 16'h8100;
      {fb[p+2], fb[p+3]} = 16'h0005;
      p += 4;
    end
    {fb[p], fb[p+1]} = lt;
    {fb[p+2], fb[p+3]} = op;
    exp_q.push_back(model(len, kind, ntags, lt, op, err, skip));
    tag_q.push_back(tag);
    for (int i = 0; i < len; i++) begin
      if (i == gap_at) idle(1);
      @(negedge clk);
      i_vld = 1'b1; i_sof = (i == 0); i_eof = (i == len - 1);
      i_data = fb[i]; i_fcs_err = err; i_skip_crc = skip;
    end
  endtask

  task automatic fr(string tag, int len, int kind, logic [15:0] lt, bit err);
    send(tag, len, kind, 0, lt, 16'h0000, err, 1'b0, -1);
    idle(1);
  endtask

  // Monitor: at posedge+2ns the inputs still hold what the edge latched.
  initial begin
    forever begin
      @(posedge clk);
      #2ns;
      if (rst_n && !done) begin
        if (i_vld && i_sof) begin
          checks++;
          if (!o_stat[0]) begin
            fails++;
            $display("FAIL R2 start strobe: actual %b expected 1", o_stat[0]);
          end
        end else if (o_stat[0]) begin
          fails++;
          $display("FAIL R2 stray start strobe: actual 1 expected 0");
        end
        if (i_vld && i_eof) begin
          logic [30:0] e;
          string t;
          checks++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R12 unexpected end: actual %h expected none", o_stat);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (o_stat[30:1] !== e[30:1]) begin
              fails++;
              $display("FAIL %s: actual %h expected %h", t, o_stat[30:1], e[30:1]);
            end
          end
        end else if (o_stat[30:1] != '0) begin
          fails++;
          $display("FAIL R12 end strobes without end beat: actual %h expected 0", o_stat[30:1]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    i_vld = 0; i_sof = 0; i_eof = 0; i_data = 0; i_fcs_err = 0; i_skip_crc = 0;
    i_max_size = 16'd1518; i_vlan_en = 0; i_len_chk_en = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (o_stat !== '0) begin fails++; $display("FAIL R1 in reset: actual %h expected 0", o_stat); end
    rst_n = 1'b1;
    idle(3);
    checks++;
    if (o_stat !== '0) begin fails++; $display("FAIL R1 after reset: actual %h expected 0", o_stat); end

    // R3 bin edges with headroom above the standard maximum
    i_max_size = 16'd2000;
    fr("R3 len63", 63, 0, 16'h0800, 0);
    fr("R3 len64", 64, 0, 16'h0800, 0);
    fr("R3 len65", 65, 0, 16'h0800, 0);
    fr("R3 len127", 127, 0, 16'h0800, 0);
    fr("R3 len128", 128, 0, 16'h0800, 0);
    fr("R3 len255", 255, 0, 16'h0800, 0);
    fr("R3 len256", 256, 0, 16'h0800, 0);
    fr("R3 len511", 511, 0, 16'h0800, 0);
    fr("R3 len512", 512, 0, 16'h0800, 0);
    fr("R3 len1023", 1023, 0, 16'h0800, 0);
    fr("R3 len1024", 1024, 0, 16'h0800, 0);
    fr("R3 len1518", 1518, 0, 16'h0800, 0);
    fr("R3 len1519", 1519, 0, 16'h0800, 0);
    fr("R3 len2000 at max", 2000, 0, 16'h0800, 0);
    fr("R4 len2001 over", 2001, 0, 16'h0800, 0);
    i_max_size = 16'd1518;
    fr("R4 len1519 over", 1519, 0, 16'h0800, 0);
    i_max_size = 16'd1000;
    fr("R4 len1001 over low max", 1001, 1, 16'h0800, 0);
    fr("R3 len1000 at low max", 1000, 1, 16'h0800, 0);
    i_max_size = 16'd1518;

    // R5 CRC error by size
    fr("R5 fragment", 40, 0, 16'h0800, 1);
    fr("R5 jabber", 1600, 0, 16'h0800, 1);
    fr("R5 legal size crc", 100, 0, 16'h0800, 1);
    fr("R5 crc at 64", 64, 2, 16'h0800, 1);

    // R6 destination class, good and errored, data and control
    fr("R6 mcast data ok", 80, 1, 16'h0800, 0);
    fr("R6 bcast data ok", 80, 2, 16'h0800, 0);
    fr("R6 mcast data err", 80, 1, 16'h0800, 1);
    fr("R6 bcast data err", 80, 2, 16'h0800, 1);
    send("R6 ucast ctrl other op", 64, 0, 0, 16'h8808, 16'h0002, 0, 0, -1); idle(1);
    send("R6 bcast ctrl err", 64, 2, 0, 16'h8808, 16'h0003, 1, 0, -1); idle(1);

    // R7 pause and priority flow control
    send("R7 pause ok", 64, 1, 0, 16'h8808, 16'h0001, 0, 0, -1); idle(1);
    send("R7 pause err", 64, 1, 0, 16'h8808, 16'h0001, 1, 0, -1); idle(1);
    send("R7 pfc ok", 64, 0, 0, 16'h8808, 16'h0101, 0, 0, -1); idle(1);
    send("R7 pfc err", 64, 2, 0, 16'h8808, 16'h0101, 1, 0, -1); idle(1);
    send("R7 pause op not ctrl", 64, 0, 0, 16'h0800, 16'h0001, 0, 0, -1); idle(1);

    // R8 dead band edges
    fr("R8 lt1500", 1520, 0, 16'd1500, 0);
    fr("R8 lt1501", 200, 0, 16'd1501, 0);
    fr("R8 lt1535", 200, 0, 16'd1535, 0);
    fr("R8 lt1536", 200, 0, 16'd1536, 0);

    // R9 tag look-through
    i_vlan_en = 1'b1;
    send("R9 one tag pause", 68, 0, 1, 16'h8808, 16'h0001, 0, 0, -1); idle(1);
    send("R9 two tags bad lt", 100, 0, 2, 16'd1510, 16'h0000, 0, 0, -1); idle(1);
    i_vlan_en = 1'b0;
    send("R9 one tag no look", 68, 0, 1, 16'h8808, 16'h0001, 0, 0, -1); idle(1);
    send("R9 two tags no look", 100, 0, 2, 16'd1510, 16'h0000, 0, 0, -1); idle(1);

    // R10 advertised length
    i_len_chk_en = 1'b1;
    fr("R10 lt100 in 64", 64, 0, 16'd100, 0);
    fr("R10 lt46 in 64", 64, 0, 16'd46, 0);
    fr("R10 lt47 in 64", 64, 0, 16'd47, 0);
    fr("R10 short frame", 16, 0, 16'd2, 0);
    i_vlan_en = 1'b1;
    send("R10 tagged lt46", 68, 0, 1, 16'd46, 16'h0000, 0, 0, -1); idle(1);
    send("R10 tagged lt47", 68, 0, 1, 16'd47, 16'h0000, 0, 0, -1); idle(1);
    i_vlan_en = 1'b0;
    i_len_chk_en = 1'b0;
    fr("R10 check off", 64, 0, 16'd100, 0);

    // R11 dropped runts with skip-CRC
    send("R11 skip len20", 20, 0, 0, 16'h0800, 16'h0000, 0, 1, -1); idle(1);
    send("R11 skip len20 err", 20, 1, 0, 16'h0800, 16'h0000, 1, 1, -1); idle(1);
    send("R11 skip len21", 21, 0, 0, 16'h0800, 16'h0000, 0, 1, -1); idle(1);
    send("R11 skip len64", 64, 2, 0, 16'h0800, 16'h0000, 0, 1, -1); idle(1);

    // R12 idle beats inside frames and back-to-back frames
    send("R12 gap in header", 70, 1, 0, 16'h8808, 16'h0001, 0, 0, 3);
    send("R12 back to back", 64, 2, 0, 16'h0800, 16'h0000, 0, 0, 13);
    send("R12 back to back 2", 130, 0, 0, 16'd1520, 16'h0000, 1, 0, -1);
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R12 missing end strobes: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule